// File: doc/BRIEF.md
# Serial EEPROM Boot Configuration Loader

After reset this block fills a configuration register image, one byte per write, over a byte-wide write port. Loading starts when `start` is pulsed. If `eeprom_mode` is high at that moment, the block acts as a two-wire bus master and fetches the image from a serial EEPROM. It first selects word address zero and then reads the bytes back-to-back in one sequential read. The first two bytes act as a signature. Only when both match the expected values does the block write the EEPROM contents into the image.

In every other case the block writes a computed set of built-in defaults into all locations. This covers a mode input that is low, a wrong signature, and a device that does not acknowledge. `done` holds the rest of the chip until the image is complete. The image is captured once per reset: changes to the EEPROM or to the mode input take effect only after the next reset.

The bus pins are a push-pull clock and an open-drain style data line. The block never drives data high; it only enables a low. The serial clock is derived from the system clock. Every phase of a bit lasts `QTR_CYC` system clocks.

Top module: `cfg_boot_loader`

## Requirements
- R1: While `rst_n` is low, `done` and `cfg_we` are 0, `scl_o` is 1 and `sda_oe` is 0.
- R2: With `eeprom_mode` low at `start`, the block writes address a = 0,1,...,109 in ascending order with data ((3*a) mod 256) XOR 0xA5. SCL never toggles during this load.
- R3: With `eeprom_mode` high, the block sends a start, then device address 0x50 with the write bit (byte 0xA0), then one word-address byte 0x00, then a repeated start and 0xA1. It then reads sequentially. When the signature is valid, EEPROM byte k is written to address k for k = 0..109, in ascending order.
- R4: If EEPROM byte 0 is not 0x95 or byte 1 is not 0x00, the block writes no EEPROM data. It NACKs byte 1, issues a stop, and writes the R2 defaults, so only two bytes are fetched.
- R5: If the device address byte is not acknowledged, the block issues a stop and writes the R2 defaults.
- R6: SDA changes only while SCL is low, except for start and stop conditions. A valid load shows exactly two start conditions and one stop.
- R7: The master ACKs every fetched byte except byte 109. It NACKs byte 109 and then issues a stop, so exactly 110 bytes are fetched.
- R8: `done` stays low until the last image write has occurred and rises after it. It then stays high until reset. No write occurs while `done` is high, and a later `start` has no effect.
- R9: Every complete SCL high pulse lasts exactly 2*`QTR_CYC` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin loading (acted on once per reset) |
| eeprom_mode | input | 1 | 1 = attempt EEPROM load, 0 = defaults only |
| scl_o | output | 1 | Serial clock |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| sda_in | input | 1 | Resolved level of the data line |
| cfg_we | output | 1 | Image write strobe |
| cfg_addr | output | 7 | Image write address |
| cfg_data | output | 8 | Image write data |
| done | output | 1 | Image complete, stays high until reset |

## Verification
The assertions assume the following about the EEPROM: it changes the data line only while SCL is low, it never stretches the clock, and no second master is on the bus. They also assume `start` is a single pulse given after reset. The bench meets these conditions. Its EEPROM model updates its data output only on falling SCL edges, and `start` is driven as one-cycle pulses on the falling system clock edge. The bus scenarios cover a valid image, a bad first signature byte, a bad second signature byte and an unanswered device address. A run with the mode input low and a late `start` after completion are also included.

// File: rtl/cfg_boot_pkg.sv
`timescale 1ns/1ps
package cfg_boot_pkg;

   typedef enum logic [1:0] {
      TW_START = 2'd0,
      TW_STOP  = 2'd1,
      TW_WRITE = 2'd2,
      TW_READ  = 2'd3
   } tw_cmd_e;

   typedef enum logic [3:0] {
      LD_IDLE, LD_START1, LD_DEVW, LD_WADDR, LD_START2, LD_DEVR,
      LD_READ, LD_SIG0, LD_SIG1, LD_ABORT, LD_FINISH, LD_DEFLT, LD_DONE
   } ld_state_e;

   // built-in default for image location a
   function automatic logic [7:0] cfg_default_byte(input int unsigned a);
      logic [7:0] m;
      m = 8'(a * 3);
      return m ^ 8'hA5;
   endfunction

endpackage

// File: rtl/cfg_twi_tick.sv
`timescale 1ns/1ps
module cfg_twi_tick #(
   parameter int unsigned QTR_CYC = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic tick
);
   localparam int unsigned CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
   localparam logic [CW-1:0] LIM = CW'(QTR_CYC - 1);

   logic [CW-1:0] cnt;

   if (QTR_CYC < 1) begin : g_bad_div
      $error("cfg_twi_tick: QTR_CYC must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear || cnt == LIM) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign tick = !clear && (cnt == LIM);

endmodule

// File: rtl/cfg_twi_byte_engine.sv
`timescale 1ns/1ps
module cfg_twi_byte_engine
   import cfg_boot_pkg::*;
#(
   parameter int unsigned QTR_CYC = 125
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  tw_cmd_e    cmd,
   input  logic [7:0] tx_byte,
   input  logic       ack_out,
   output logic       ready,
   output logic       done,
   output logic [7:0] rx_byte,
   output logic       rx_ack,
   output logic       scl_o,
   output logic       sda_oe,
   input  logic       sda_in
);
   localparam int unsigned SLOTS   = 9;
   localparam int unsigned SLOT_W  = $clog2(SLOTS);
   localparam logic [SLOT_W-1:0] ACK_SLOT = SLOT_W'(SLOTS - 1);

   logic              busy;
   tw_cmd_e           cur;
   logic [SLOT_W-1:0] slot;
   logic [1:0]        ph;
   logic [7:0]        sh;
   logic              scl_h, oe_h;
   logic              tick;
   logic              is_data;
   logic              drv_low;
   logic              scl_c, oe_c;

   cfg_twi_tick #(.QTR_CYC(QTR_CYC)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (!busy),
      .tick  (tick)
   );

   assign is_data = (cur == TW_WRITE) || (cur == TW_READ);

   always_comb begin
      if (cur == TW_WRITE) begin
         drv_low = (slot == ACK_SLOT) ? 1'b0 : !sh[7];
      end else begin
         drv_low = (slot == ACK_SLOT) ? ack_out : 1'b0;
      end
   end

   // phase waveform table: start and stop move SDA with SCL high on purpose
   always_comb begin
      scl_c = scl_h;
      oe_c  = oe_h;
      if (busy) begin
         unique case (cur)
            TW_START: begin
               scl_c = (ph == 2'd1) || (ph == 2'd2);
               oe_c  = (ph == 2'd2) || (ph == 2'd3);
            end
            TW_STOP: begin
               scl_c = (ph != 2'd0);
               oe_c  = (ph == 2'd0) || (ph == 2'd1);
            end
            default: begin
               scl_c = (ph == 2'd1) || (ph == 2'd2);
               oe_c  = drv_low;
            end
         endcase
      end
   end

   assign scl_o   = scl_c;
   assign sda_oe  = oe_c;
   assign ready   = !busy;
   assign rx_byte = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cur    <= TW_START;
         slot   <= '0;
         ph     <= 2'd0;
         sh     <= 8'h00;
         scl_h  <= 1'b1;
         oe_h   <= 1'b0;
         done   <= 1'b0;
         rx_ack <= 1'b0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            scl_h <= scl_c;
            oe_h  <= oe_c;
         end
         if (cmd_valid && !busy) begin
            busy <= 1'b1;
            cur  <= cmd;
            slot <= '0;
            ph   <= 2'd0;
            sh   <= (cmd == TW_WRITE) ? tx_byte : 8'h00;
         end else if (busy && tick) begin
            if (ph == 2'd2 && is_data) begin
               if (cur == TW_READ && slot != ACK_SLOT) begin
                  sh <= {sh[6:0], sda_in};
               end
               if (cur == TW_WRITE && slot == ACK_SLOT) begin
                  rx_ack <= !sda_in;
               end
            end
            if (ph == 2'd3) begin
               ph <= 2'd0;
               if (!is_data || slot == ACK_SLOT) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  slot <= slot + 1'b1;
                  if (cur == TW_WRITE) begin
                     sh <= {sh[6:0], 1'b0};
                  end
               end
            end else begin
               ph <= ph + 2'd1;
            end
         end
      end
   end

   // R6: within one data or ack bit, SDA holds while SCL is high
   a_r6_sda_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_o && $past(scl_o) && busy && $past(busy) && is_data) |-> $stable(sda_oe));

   // R3: the sequencer never issues a command while one is running
   a_r3_cmd_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !busy);

   // R9: completion is only reported in a phase where SCL is not left high mid-bit
   a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

endmodule

// File: rtl/cfg_boot_loader.sv
`timescale 1ns/1ps
module cfg_boot_loader
   import cfg_boot_pkg::*;
#(
   parameter int unsigned NUM_BYTES       = 110,
   parameter logic [6:0]  DEV_ADDR        = 7'h50,
   parameter logic [7:0]  SIG_HI          = 8'h95,
   parameter logic [7:0]  SIG_LO          = 8'h00,
   parameter int unsigned QTR_CYC         = 125,
   parameter int unsigned WORD_ADDR_BYTES = 1,
   localparam int unsigned IDX_W          = $clog2(NUM_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             eeprom_mode,
   output logic             scl_o,
   output logic             sda_oe,
   input  logic             sda_in,
   output logic             cfg_we,
   output logic [IDX_W-1:0] cfg_addr,
   output logic [7:0]       cfg_data,
   output logic             done
);
   localparam logic [IDX_W-1:0] LAST  = IDX_W'(NUM_BYTES - 1);
   localparam int unsigned      WAB_W = 2;
   localparam logic [WAB_W-1:0] WAB_LAST = WAB_W'(WORD_ADDR_BYTES - 1);

   if (NUM_BYTES < 3) begin : g_bad_len
      $error("cfg_boot_loader: NUM_BYTES must cover the signature and data");
   end
   if (WORD_ADDR_BYTES < 1 || WORD_ADDR_BYTES > 2) begin : g_bad_wab
      $error("cfg_boot_loader: WORD_ADDR_BYTES must be 1 or 2");
   end
   if (NUM_BYTES > (1 << (8 * WORD_ADDR_BYTES))) begin : g_bad_span
      $error("cfg_boot_loader: image larger than the word address range");
   end

   ld_state_e        state;
   logic             pend;
   logic [IDX_W-1:0] idx;
   logic [WAB_W-1:0] wab;
   logic [7:0]       byte0, byte1;

   logic       eng_valid, eng_ready, eng_done, eng_ack;
   tw_cmd_e    eng_cmd;
   logic [7:0] eng_tx, eng_rx;
   logic       rd_ack, need_bus, sig_ok_now;

   assign sig_ok_now = (byte0 == SIG_HI) && (eng_rx == SIG_LO);

   always_comb begin
      need_bus = 1'b1;
      eng_cmd  = TW_START;
      eng_tx   = 8'h00;
      unique case (state)
         LD_START1, LD_START2: eng_cmd = TW_START;
         LD_DEVW:   begin eng_cmd = TW_WRITE; eng_tx = {DEV_ADDR, 1'b0}; end
         LD_WADDR:  begin eng_cmd = TW_WRITE; eng_tx = 8'h00; end
         LD_DEVR:   begin eng_cmd = TW_WRITE; eng_tx = {DEV_ADDR, 1'b1}; end
         LD_READ:   eng_cmd = TW_READ;
         LD_ABORT, LD_FINISH: eng_cmd = TW_STOP;
         default:   need_bus = 1'b0;
      endcase
   end

   // ACK decision is taken from the byte just shifted in, before the ack bit
   assign rd_ack = (idx != LAST) &&
                   !((idx == IDX_W'(1)) && !sig_ok_now);

   assign eng_valid = need_bus && eng_ready && !pend;

   cfg_twi_byte_engine #(.QTR_CYC(QTR_CYC)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (eng_valid),
      .cmd       (eng_cmd),
      .tx_byte   (eng_tx),
      .ack_out   (rd_ack),
      .ready     (eng_ready),
      .done      (eng_done),
      .rx_byte   (eng_rx),
      .rx_ack    (eng_ack),
      .scl_o     (scl_o),
      .sda_oe    (sda_oe),
      .sda_in    (sda_in)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= LD_IDLE;
         pend     <= 1'b0;
         idx      <= '0;
         wab      <= '0;
         byte0    <= 8'h00;
         byte1    <= 8'h00;
         cfg_we   <= 1'b0;
         cfg_addr <= '0;
         cfg_data <= 8'h00;
         done     <= 1'b0;
      end else begin
         cfg_we <= 1'b0;
         if (eng_valid) pend <= 1'b1;
         if (eng_done)  pend <= 1'b0;
         unique case (state)
            LD_IDLE: if (start) begin
               idx   <= '0;
               state <= eeprom_mode ? LD_START1 : LD_DEFLT;
            end
            LD_START1: if (eng_done) state <= LD_DEVW;
            LD_DEVW: if (eng_done) begin
               wab   <= '0;
               state <= eng_ack ? LD_WADDR : LD_ABORT;
            end
            LD_WADDR: if (eng_done) begin
               if (!eng_ack)          state <= LD_ABORT;
               else if (wab == WAB_LAST) state <= LD_START2;
               else                   wab   <= wab + 1'b1;
            end
            LD_START2: if (eng_done) state <= LD_DEVR;
            LD_DEVR: if (eng_done) state <= eng_ack ? LD_READ : LD_ABORT;
            LD_READ: if (eng_done) begin
               if (idx == '0) begin
                  byte0 <= eng_rx;
                  idx   <= IDX_W'(1);
               end else if (idx == IDX_W'(1)) begin
                  byte1 <= eng_rx;
                  state <= sig_ok_now ? LD_SIG0 : LD_ABORT;
               end else begin
                  cfg_we   <= 1'b1;
                  cfg_addr <= idx;
                  cfg_data <= eng_rx;
                  if (idx == LAST) state <= LD_FINISH;
                  else             idx   <= idx + 1'b1;
               end
            end
            LD_SIG0: begin
               cfg_we   <= 1'b1;
               cfg_addr <= '0;
               cfg_data <= byte0;
               state    <= LD_SIG1;
            end
            LD_SIG1: begin
               cfg_we   <= 1'b1;
               cfg_addr <= IDX_W'(1);
               cfg_data <= byte1;
               idx      <= IDX_W'(2);
               state    <= LD_READ;
            end
            LD_ABORT: if (eng_done) begin
               idx   <= '0;
               state <= LD_DEFLT;
            end
            LD_FINISH: if (eng_done) state <= LD_DONE;
            LD_DEFLT: begin
               cfg_we   <= 1'b1;
               cfg_addr <= idx;
               cfg_data <= cfg_default_byte(int'(idx));
               if (idx == LAST) state <= LD_DONE;
               else             idx   <= idx + 1'b1;
            end
            LD_DONE: done <= 1'b1;
            default: state <= LD_IDLE;
         endcase
      end
   end

   // R8: once raised, done holds until reset
   a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(done) |-> done);

   // R8: no image write is seen once done is up
   a_r8_no_write_when_done: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |-> !done);

   // R3: every write lands inside the image
   a_r3_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |-> (cfg_addr <= LAST));

   // R2: while defaults are written the bus sits idle
   a_r2_bus_quiet_defaults: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LD_DEFLT) |-> (scl_o && !sda_oe));

endmodule

// File: tb/sim_cfg_boot_loader.sv
`timescale 1ns/1ps
module sim_cfg_boot_loader;
   localparam int N = 110;
   localparam int Q = 2;
   localparam logic [6:0] DEV = 7'h50;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       mode = 1'b0;
   logic       scl, oe, cfg_we, done;
   logic [6:0] cfg_addr;
   logic [7:0] cfg_data;
   logic       s_low = 1'b0;
   logic       sda_line;

   assign sda_line = !(oe || s_low);

   always #2.5 clk = ~clk;

   cfg_boot_loader #(.NUM_BYTES(N), .DEV_ADDR(DEV), .QTR_CYC(Q)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .eeprom_mode(mode),
      .scl_o(scl), .sda_oe(oe), .sda_in(sda_line),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .done(done));

   int nchk = 0, nfail = 0;
   bit finished = 0;
   string cur_req = "R2";
   logic [14:0] exp_q[$];

   task automatic chk(input bit ok, input string req, input string msg,
                      input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, msg, act, exp);
      end
   endtask

   function automatic logic [7:0] bdef(input int a);
      return 8'((a * 3) % 256) ^ 8'hA5;
   endfunction

   // ---------------- EEPROM model ----------------
   logic [7:0] mem [0:255];
   bit   nack_dev = 0;
   int   s_mode = 0, s_bit = 0, s_txn = 0, s_starts = 0, s_stops = 0;
   logic [7:0] s_sh = 8'h00, s_ptr = 8'h00;
   bit   s_rw = 0, s_ack_m = 0;

   task automatic s_load();
      s_sh  = mem[s_ptr];
      s_low = !s_sh[7];
      s_txn++;
   endtask

   always @(negedge sda_line) if (scl === 1'b1) begin
      s_starts++; s_mode = 1; s_bit = 0; s_low = 0;
   end
   always @(posedge sda_line) if (scl === 1'b1) begin
      s_stops++; s_mode = 0; s_low = 0;
   end
   always @(posedge scl) begin
      if (s_mode == 1 || s_mode == 2) begin
         if (s_bit < 8) s_sh = {s_sh[6:0], sda_line};
         s_bit++;
      end else if (s_mode == 3) begin
         if (s_bit == 8) s_ack_m = !sda_line;
         s_bit++;
      end
   end
   always @(negedge scl) begin
      case (s_mode)
         1: if (s_bit == 8) begin
               if (s_sh[7:1] == DEV && !nack_dev) begin s_low = 1; s_rw = s_sh[0]; end
               else begin s_mode = 4; s_low = 0; end
            end else if (s_bit == 9) begin
               s_low = 0; s_bit = 0;
               if (s_rw) begin s_mode = 3; s_load(); end
               else s_mode = 2;
            end
         2: if (s_bit == 8) begin s_ptr = s_sh; s_low = 1; end
            else if (s_bit == 9) begin s_low = 0; s_bit = 0; end
         3: if (s_bit >= 1 && s_bit <= 7) s_low = !s_sh[7 - s_bit];
            else if (s_bit == 8) s_low = 0;
            else if (s_bit == 9) begin
               s_bit = 0;
               if (s_ack_m) begin s_ptr = s_ptr + 8'd1; s_load(); end
               else begin s_mode = 4; s_low = 0; end
            end
         default: ;
      endcase
   end

   // ---------------- monitor / scoreboard ----------------
   bit prev_done = 0, prev_scl = 1, in_hi = 0;
   int hw = 0, hmin = 0, hmax = 0, falls = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (cfg_we) begin
            if (exp_q.size() == 0) chk(0, "R8", "write with nothing expected", cfg_addr, 0);
            else begin
               logic [14:0] e;
               e = exp_q.pop_front();
               chk({cfg_addr, cfg_data} == e, cur_req, "image write {addr,data}",
                   {cfg_addr, cfg_data}, e);
            end
         end
         if (done && !prev_done)
            chk(exp_q.size() == 0, "R8", "writes left when done rose", exp_q.size(), 0);
         if (scl && !prev_scl) begin in_hi = 1; hw = 1; end
         else if (scl && in_hi) hw++;
         else if (!scl && prev_scl) begin
            falls++;
            if (in_hi) begin
               if (hmin == 0 || hw < hmin) hmin = hw;
               if (hw > hmax) hmax = hw;
            end
            in_hi = 0;
         end
         prev_done = done;
         prev_scl  = scl;
      end else begin
         prev_done = 0; prev_scl = 1; in_hi = 0;
      end
   end

   // ---------------- driver ----------------
   task automatic do_reset();
      rst_n = 0;
      exp_q.delete();
      s_mode = 0; s_bit = 0; s_low = 0; s_txn = 0; s_starts = 0; s_stops = 0;
      repeat (4) @(negedge clk);
      chk(done == 0 && cfg_we == 0, "R1", "done/we in reset", {done, cfg_we}, 0);
      chk(scl == 1 && oe == 0, "R1", "bus idle in reset", {scl, oe}, 2'b10);
      rst_n = 1;
      repeat (2) @(negedge clk);
   endtask

   task automatic run_case(input bit m, input string req, input bit use_mem,
                           input int exp_txn, input int exp_st, input int exp_sp);
      cur_req = req;
      mode = m;
      for (int a = 0; a < N; a++)
         exp_q.push_back({7'(a), use_mem ? mem[a] : bdef(a)});
      hmin = 0; hmax = 0; falls = 0;
      @(negedge clk) start = 1;
      @(negedge clk) start = 0;
      repeat (10) @(negedge clk);
      chk(done == 0, "R8", "done low while loading", done, 0);
      for (int i = 0; i < 100000 && !done; i++) @(negedge clk);
      chk(done == 1, "R8", "done after load", done, 1);
      chk(exp_q.size() == 0, req, "missing image writes", exp_q.size(), 0);
      chk(s_txn == exp_txn, "R7", "bytes fetched", s_txn, exp_txn);
      chk(s_starts == exp_st && s_stops == exp_sp, "R6", "start/stop events",
          {s_starts, s_stops}, {exp_st, exp_sp});
      if (m) chk(hmin == 2*Q && hmax == 2*Q, "R9", "SCL high width", {hmin, hmax}, {2*Q, 2*Q});
      else   chk(falls == 0, "R2", "SCL falls in default load", falls, 0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'((i * 7 + 1) % 256) ^ 8'h3C;
      mem[0] = 8'h95; mem[1] = 8'h00;

      // R2: defaults when the mode input is low
      do_reset();
      run_case(0, "R2", 0, 0, 0, 0);

      // R3, R7: valid signature
      do_reset();
      run_case(1, "R3", 1, N, 2, 1);
      // R8: a later start is ignored
      @(negedge clk) start = 1;
      @(negedge clk) start = 0;
      repeat (500) @(negedge clk);
      chk(done == 1 && s_starts == 2, "R8", "late start ignored", {done, s_starts}, {1'b1, 2});

      // R4: wrong first signature byte
      mem[0] = 8'h94;
      do_reset();
      run_case(1, "R4", 0, 2, 2, 1);

      // R4: wrong second signature byte
      mem[0] = 8'h95; mem[1] = 8'h01;
      do_reset();
      run_case(1, "R4", 0, 2, 2, 1);

      // R5: device does not acknowledge
      mem[1] = 8'h00; nack_dev = 1;
      do_reset();
      run_case(1, "R5", 0, 0, 1, 1);
      nack_dev = 0;

      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         chk(0, "R8", "watchdog expired", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

endmodule